// File: doc/BRIEF.md
# IOMMU Register-Driven Cache Invalidation Unit

This block is the hardware end of a register-driven invalidation path in an IO memory-management unit. It holds two 64-bit command registers on a simple memory-mapped bus. The first register controls a context cache, which is tagged by source id and domain id. The second register controls an IOTLB, which is tagged by domain id. Software writes a command with the busy bit set, a requested granularity and the identifiers. The unit then walks the matching tag store, one entry per clock, and clears every entry the request selects. At the end it drops the busy bit and writes back the granularity it actually carried out. Software polls the busy bit before it issues a command and again until the command finishes.

The IOTLB command can ask the unit to drain outstanding requests first. In that case completion also waits until an external outstanding-request count reaches zero. The tag stores are filled through dedicated fill ports, and their valid bits are visible as outputs.

Top module: `iommu_inval_unit`

## Requirements
- R1: After reset both command registers read as zero and every valid bit of both tag stores is 0.
- R2: The context command register sits at byte address 0x28. A write with bit 63 clear stores only the writable fields and starts nothing. The writable fields are requested granularity [62:61], source id [31:16] and domain id [15:0]. The actual-granularity field [60:59] is never written by the bus, and every other bit reads 0.
- R3: A global request (granularity 1) clears every valid entry of the addressed store.
- R4: A domain request (granularity 2) clears exactly the entries whose domain id equals the command's domain id.
- R5: A device request (granularity 3) on the context register clears exactly the context entries whose source id and domain id both match.
- R6: Without a drain hold, the busy bit [63] reads 1 for exactly entries+1 clock cycles after the starting write, then reads 0.
- R7: On completion, the context actual-granularity field equals the requested one. A requested granularity of 0 reports 0 and clears nothing.
- R8: An IOTLB request with granularity 3 clears nothing and reports actual granularity 0.
- R9: A write to a command register while its busy bit is set has no effect on that register or on its invalidation.
- R10: When the IOTLB command has drain-reads [49] or drain-writes [48] set, busy stays set while the outstanding-request count is nonzero. Busy clears one cycle after the count reaches zero.
- R11: The IOTLB register sits at byte address IOTLB_WIN+8. Its writable fields are requested granularity [61:60], drain flags [49:48] and domain id [47:32]. The actual granularity sits at [58:57], and granularities 1 and 2 are reported unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Bus byte address |
| busWrData | input | 64 | Bus write data |
| busRdData | output | 64 | Read data for busAddr (combinational) |
| ctxFillEn | input | 1 | Load a context cache entry |
| ctxFillIdx | input | clog2(CTX_ENTRIES) | Context entry index |
| ctxFillSid | input | 16 | Source id for the fill |
| ctxFillDid | input | 16 | Domain id for the fill |
| tlbFillEn | input | 1 | Load an IOTLB entry |
| tlbFillIdx | input | clog2(TLB_ENTRIES) | IOTLB entry index |
| tlbFillDid | input | 16 | Domain id for the fill |
| pendingReqs | input | CNT_W | Outstanding-request count used by drain |
| ctxValid | output | CTX_ENTRIES | Context cache valid bits |
| tlbValid | output | TLB_ENTRIES | IOTLB valid bits |

## Verification
The bench fills the stores with ids drawn from a narrow range, so that domain and device matches happen often. It then issues random commands on both registers with every granularity code from 0 to 3. Domain and device requests against the same contents tell whether the source id takes part in the match. Global requests tell a full walk apart from an early stop. Codes 0 and an IOTLB code 3 show that a failed request leaves the store untouched. Directed cases cover field masking, a rewrite while busy and a held drain with a nonzero count.

// File: rtl/inval_pkg.sv
package inval_pkg;
  localparam int ID_W = 16;
  localparam logic [1:0] GRAN_NONE   = 2'd0;
  localparam logic [1:0] GRAN_GLOBAL = 2'd1;
  localparam logic [1:0] GRAN_DOMAIN = 2'd2;
  localparam logic [1:0] GRAN_DEVICE = 2'd3;
  localparam logic [63:0] CTX_WMASK = 64'h6000_0000_FFFF_FFFF;
  localparam logic [63:0] TLB_WMASK = 64'h3003_FFFF_0000_0000;

  typedef struct packed {
    logic walk;
    logic finish;
  } invStrobeT;
endpackage

// File: rtl/inval_ctrl.sv
module inval_ctrl
  import inval_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             drainHold,
  output invStrobeT        stb,
  output logic [IDX_W-1:0] walkIdx
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_FIN} stateT;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  stateT state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_WALK;
          idx   <= '0;
        end
        S_WALK: begin
          if (idx == LAST) state <= S_FIN;
          else idx <= idx + 1'b1;
        end
        S_FIN: if (!drainHold) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.walk   = (state == S_WALK);
    stb.finish = (state == S_FIN) && !drainHold;
    walkIdx    = idx;
  end
endmodule

// File: rtl/inval_datapath.sv
module inval_datapath
  import inval_pkg::*;
#(
  parameter int CTX_ENTRIES = 8,
  parameter int TLB_ENTRIES = 8,
  localparam int CIDX_W = $clog2(CTX_ENTRIES),
  localparam int TIDX_W = $clog2(TLB_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctxWr,
  input  logic              tlbWr,
  input  logic [63:0]       wrData,
  input  invStrobeT         ctxStb,
  input  logic [CIDX_W-1:0] ctxIdx,
  input  invStrobeT         tlbStb,
  input  logic [TIDX_W-1:0] tlbIdx,
  input  logic              ctxFillEn,
  input  logic [CIDX_W-1:0] ctxFillIdx,
  input  logic [ID_W-1:0]   ctxFillSid,
  input  logic [ID_W-1:0]   ctxFillDid,
  input  logic              tlbFillEn,
  input  logic [TIDX_W-1:0] tlbFillIdx,
  input  logic [ID_W-1:0]   tlbFillDid,
  output logic [63:0]       ctxReg,
  output logic [63:0]       tlbReg,
  output logic              ctxStart,
  output logic              tlbStart,
  output logic [CTX_ENTRIES-1:0] ctxValid,
  output logic [TLB_ENTRIES-1:0] tlbValid
);
  logic [ID_W-1:0] ctxSid [CTX_ENTRIES];
  logic [ID_W-1:0] ctxDid [CTX_ENTRIES];
  logic [ID_W-1:0] tlbDid [TLB_ENTRIES];

  logic ctxHit, tlbHit;
  logic [1:0] ctxAct, tlbAct;

  assign ctxStart = ctxWr && !ctxReg[63] && wrData[63];
  assign tlbStart = tlbWr && !tlbReg[63] && wrData[63];

  // Entry under the walk pointer matches the latched command
  always_comb begin
    unique case (ctxReg[62:61])
      GRAN_GLOBAL: ctxHit = 1'b1;
      GRAN_DOMAIN: ctxHit = ctxDid[ctxIdx] == ctxReg[15:0];
      GRAN_DEVICE: ctxHit = (ctxDid[ctxIdx] == ctxReg[15:0]) &&
                            (ctxSid[ctxIdx] == ctxReg[31:16]);
      default:     ctxHit = 1'b0;
    endcase
    unique case (tlbReg[61:60])
      GRAN_GLOBAL: tlbHit = 1'b1;
      GRAN_DOMAIN: tlbHit = tlbDid[tlbIdx] == tlbReg[47:32];
      default:     tlbHit = 1'b0;  // device scope unsupported on IOTLB
    endcase
    ctxAct = ctxReg[62:61];
    tlbAct = (tlbReg[61:60] == GRAN_DEVICE) ? GRAN_NONE : tlbReg[61:60];
  end

  // Command registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxReg <= '0;
      tlbReg <= '0;
    end else begin
      if (ctxWr && !ctxReg[63]) begin
        ctxReg <= (wrData & CTX_WMASK) | {wrData[63], 63'b0};
        ctxReg[60:59] <= wrData[63] ? GRAN_NONE : ctxReg[60:59];
      end else if (ctxStb.finish) begin
        ctxReg[63]    <= 1'b0;
        ctxReg[60:59] <= ctxAct;
      end
      if (tlbWr && !tlbReg[63]) begin
        tlbReg <= (wrData & TLB_WMASK) | {wrData[63], 63'b0};
        tlbReg[58:57] <= wrData[63] ? GRAN_NONE : tlbReg[58:57];
      end else if (tlbStb.finish) begin
        tlbReg[63]    <= 1'b0;
        tlbReg[58:57] <= tlbAct;
      end
    end
  end

  // Tag stores: a fill in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxValid <= '0;
      tlbValid <= '0;
    end else begin
      if (ctxStb.walk && ctxHit) ctxValid[ctxIdx] <= 1'b0;
      if (ctxFillEn) ctxValid[ctxFillIdx] <= 1'b1;
      if (tlbStb.walk && tlbHit) tlbValid[tlbIdx] <= 1'b0;
      if (tlbFillEn) tlbValid[tlbFillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctxFillEn) begin
      ctxSid[ctxFillIdx] <= ctxFillSid;
      ctxDid[ctxFillIdx] <= ctxFillDid;
    end
    if (tlbFillEn) tlbDid[tlbFillIdx] <= tlbFillDid;
  end
endmodule

// File: rtl/iommu_inval_unit.sv
module iommu_inval_unit
  import inval_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int IOTLB_WIN   = 'h100,
  parameter int CTX_ENTRIES = 8,
  parameter int TLB_ENTRIES = 8,
  parameter int CNT_W       = 6,
  localparam int CIDX_W = $clog2(CTX_ENTRIES),
  localparam int TIDX_W = $clog2(TLB_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [63:0]            busWrData,
  output logic [63:0]            busRdData,
  input  logic                   ctxFillEn,
  input  logic [CIDX_W-1:0]      ctxFillIdx,
  input  logic [15:0]            ctxFillSid,
  input  logic [15:0]            ctxFillDid,
  input  logic                   tlbFillEn,
  input  logic [TIDX_W-1:0]      tlbFillIdx,
  input  logic [15:0]            tlbFillDid,
  input  logic [CNT_W-1:0]       pendingReqs,
  output logic [CTX_ENTRIES-1:0] ctxValid,
  output logic [TLB_ENTRIES-1:0] tlbValid
);
  localparam logic [ADDR_W-1:0] CTX_ADDR = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] TLB_ADDR = ADDR_W'(IOTLB_WIN + 8);

  logic ctxSel, tlbSel, ctxStart, tlbStart, drainHold;
  logic [63:0] ctxRegQ, tlbRegQ;
  invStrobeT ctxStb, tlbStb;
  logic [CIDX_W-1:0] ctxIdx;
  logic [TIDX_W-1:0] tlbIdx;

  assign ctxSel    = busAddr == CTX_ADDR;
  assign tlbSel    = busAddr == TLB_ADDR;
  assign drainHold = (tlbRegQ[49] || tlbRegQ[48]) && (pendingReqs != '0);
  assign busRdData = ctxSel ? ctxRegQ : (tlbSel ? tlbRegQ : 64'd0);

  inval_ctrl #(.ENTRIES(CTX_ENTRIES)) u_ctxCtrl (
    .clk(clk), .rstN(rstN), .start(ctxStart), .drainHold(1'b0),
    .stb(ctxStb), .walkIdx(ctxIdx));

  inval_ctrl #(.ENTRIES(TLB_ENTRIES)) u_tlbCtrl (
    .clk(clk), .rstN(rstN), .start(tlbStart), .drainHold(drainHold),
    .stb(tlbStb), .walkIdx(tlbIdx));

  inval_datapath #(.CTX_ENTRIES(CTX_ENTRIES), .TLB_ENTRIES(TLB_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN),
    .ctxWr(busWrEn && ctxSel), .tlbWr(busWrEn && tlbSel), .wrData(busWrData),
    .ctxStb(ctxStb), .ctxIdx(ctxIdx), .tlbStb(tlbStb), .tlbIdx(tlbIdx),
    .ctxFillEn(ctxFillEn), .ctxFillIdx(ctxFillIdx),
    .ctxFillSid(ctxFillSid), .ctxFillDid(ctxFillDid),
    .tlbFillEn(tlbFillEn), .tlbFillIdx(tlbFillIdx), .tlbFillDid(tlbFillDid),
    .ctxReg(ctxRegQ), .tlbReg(tlbRegQ),
    .ctxStart(ctxStart), .tlbStart(tlbStart),
    .ctxValid(ctxValid), .tlbValid(tlbValid));
endmodule

// File: rtl/inval_checker.sv
module inval_checker #(
  parameter int CTX_ENTRIES = 8,
  parameter int CNT_W       = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctxBusy,
  input logic [1:0]       ctxReq,
  input logic [1:0]       ctxAct,
  input logic [31:0]      ctxIds,
  input logic             tlbBusy,
  input logic [1:0]       tlbReq,
  input logic [1:0]       tlbAct,
  input logic [1:0]       tlbDrain,
  input logic [CNT_W-1:0] pendingReqs
);
  logic [15:0] busyCycles;

  always_ff @(posedge clk) begin
    if (!rstN) busyCycles <= '0;
    else if (ctxBusy) busyCycles <= busyCycles + 1'b1;
    else busyCycles <= '0;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctxBusy) |-> busyCycles == 16'(CTX_ENTRIES + 1));

  assert_ctx_act_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctxBusy) |-> ctxAct == ctxReq);

  assert_tlb_dev_fail_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tlbBusy) && tlbReq == 2'd3) |-> tlbAct == 2'd0);

  assert_busy_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctxBusy) && ctxBusy) |-> ($stable(ctxReq) && $stable(ctxIds) && $stable(ctxAct)));

  assert_drain_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tlbBusy) && tlbDrain != 2'd0) |-> $past(pendingReqs) == '0);
endmodule

bind iommu_inval_unit inval_checker #(.CTX_ENTRIES(CTX_ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .ctxBusy(ctxRegQ[63]), .ctxReq(ctxRegQ[62:61]), .ctxAct(ctxRegQ[60:59]),
  .ctxIds(ctxRegQ[31:0]),
  .tlbBusy(tlbRegQ[63]), .tlbReq(tlbRegQ[61:60]), .tlbAct(tlbRegQ[58:57]),
  .tlbDrain(tlbRegQ[49:48]), .pendingReqs(pendingReqs));

// File: tb/sim_iommu_inval_unit.sv
`timescale 1ns/1ps
module sim_iommu_inval_unit;
  localparam int N = 8;
  localparam logic [11:0] CTXA = 12'h028;
  localparam logic [11:0] TLBA = 12'h108;
  localparam logic [63:0] CMASK = 64'h6000_0000_FFFF_FFFF;
  localparam logic [63:0] TMASK = 64'h3003_FFFF_0000_0000;

  logic clk = 0, rstN = 0, busWrEn = 0, ctxFillEn = 0, tlbFillEn = 0;
  logic [11:0] busAddr = '0;
  logic [63:0] busWrData = '0, busRdData;
  logic [2:0] ctxFillIdx = '0, tlbFillIdx = '0;
  logic [15:0] ctxFillSid = '0, ctxFillDid = '0, tlbFillDid = '0;
  logic [5:0] pendingReqs = '0;
  logic [N-1:0] ctxValid, tlbValid;

  int checks = 0, errors = 0;
  logic [N-1:0] mCV = '0, mTV = '0;
  logic [15:0] mSid [N], mCDid [N], mTDid [N];

  always #2.5 clk = ~clk;

  iommu_inval_unit u0 (.*);

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 0;
  endtask

  task automatic fillAll();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ctxFillEn = ($urandom % 4) != 0; tlbFillEn = ($urandom % 4) != 0;
      ctxFillIdx = 3'(i); tlbFillIdx = 3'(i);
      ctxFillSid = 16'(1 + $urandom % 3); ctxFillDid = 16'(1 + $urandom % 3);
      tlbFillDid = 16'(1 + $urandom % 3);
      if (ctxFillEn) begin mCV[i] = 1; mSid[i] = ctxFillSid; mCDid[i] = ctxFillDid; end
      if (tlbFillEn) begin mTV[i] = 1; mTDid[i] = tlbFillDid; end
      @(posedge clk); #1;
      ctxFillEn = 0; tlbFillEn = 0;
    end
  endtask

  function automatic logic ctxMatch(int i, logic [1:0] g, logic [15:0] sid, logic [15:0] did);
    case (g)
      2'd1: return 1'b1;
      2'd2: return mCDid[i] == did;
      2'd3: return mCDid[i] == did && mSid[i] == sid;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic tlbMatch(int i, logic [1:0] g, logic [15:0] did);
    return g == 2'd1 || (g == 2'd2 && mTDid[i] == did);
  endfunction

  function automatic logic [63:0] expReg(bit isTlb, logic [63:0] d);
    logic [63:0] e;
    if (isTlb) begin
      e = d & TMASK;
      e[58:57] = (d[61:60] == 2'd3) ? 2'd0 : d[61:60];
    end else begin
      e = d & CMASK;
      e[60:59] = d[62:61];
    end
    return e;
  endfunction

  // Issue a command, wait for busy to clear, update model, check result
  task automatic doReq(bit isTlb, logic [63:0] d, string tag);
    int cnt = 0;
    busWrite(isTlb ? TLBA : CTXA, d);
    while (busRdData[63] && cnt < 1000) begin cnt++; @(posedge clk); #1; end
    if (isTlb) begin
      for (int i = 0; i < N; i++) if (tlbMatch(i, d[61:60], d[47:32])) mTV[i] = 0;
    end else begin
      for (int i = 0; i < N; i++) if (ctxMatch(i, d[62:61], d[31:16], d[15:0])) mCV[i] = 0;
    end
    check(cnt == N + 1, {tag, " R6 busy length"}, 64'(cnt), 64'(N + 1));
    check(busRdData == expReg(isTlb, d), {tag, " R7/R11 register after completion"},
          busRdData, expReg(isTlb, d));
    check(ctxValid == mCV, {tag, " ctx valid"}, 64'(ctxValid), 64'(mCV));
    check(tlbValid == mTV, {tag, " tlb valid"}, 64'(tlbValid), 64'(mTV));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int cnt;
    void'($urandom(32'd20240321));
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    busAddr = CTXA; #1;
    check(busRdData == 0, "R1 ctx reg reset", busRdData, 0);
    busAddr = TLBA; #1;
    check(busRdData == 0, "R1 tlb reg reset", busRdData, 0);
    check(ctxValid == 0 && tlbValid == 0, "R1 valids reset",
          64'({ctxValid, tlbValid}), 0);

    fillAll();
    // R2 plain write: masked fields only, no invalidation
    busWrite(CTXA, 64'h7FFF_FFFF_FFFF_FFFF);
    check(busRdData == 64'h6000_0000_FFFF_FFFF, "R2 ctx write mask",
          busRdData, 64'h6000_0000_FFFF_FFFF);
    repeat (N + 3) @(posedge clk); #1;
    check(ctxValid == mCV, "R2 no invalidation", 64'(ctxValid), 64'(mCV));
    // R11 IOTLB location and mask
    busWrite(TLBA, 64'h7FFF_FFFF_FFFF_FFFF);
    check(busRdData == 64'h3003_FFFF_0000_0000, "R11 tlb write mask",
          busRdData, 64'h3003_FFFF_0000_0000);
    repeat (N + 3) @(posedge clk); #1;
    check(tlbValid == mTV, "R11 no invalidation", 64'(tlbValid), 64'(mTV));

    // R5 device request
    fillAll();
    doReq(0, {1'b1, 2'd3, 29'd0, 16'd2, 16'd1}, "R5 device");
    // R4 domain requests
    fillAll();
    doReq(0, {1'b1, 2'd2, 29'd0, 16'd3, 16'd2}, "R4 ctx domain");
    doReq(1, {2'b10, 2'd2, 12'd0, 16'd3, 32'd0}, "R4 tlb domain");
    // R3 global
    fillAll();
    doReq(0, {1'b1, 2'd1, 61'd0}, "R3 ctx global");
    doReq(1, {2'b10, 2'd1, 60'd0}, "R3 tlb global");
    check(ctxValid == 0 && tlbValid == 0, "R3 all cleared", 64'({ctxValid, tlbValid}), 0);
    // R8 IOTLB device scope unsupported
    fillAll();
    doReq(1, {2'b10, 2'd3, 12'd0, 16'd1, 32'd0}, "R8 tlb device");
    // R7 granularity 0 fails
    doReq(0, {1'b1, 2'd0, 29'd0, 16'd1, 16'd1}, "R7 ctx gran0");

    // R9 write while busy is ignored
    fillAll();
    d = {1'b1, 2'd2, 29'd0, 16'd1, 16'd3};
    busWrite(CTXA, d);
    busWrite(CTXA, {1'b1, 2'd1, 29'd0, 16'd2, 16'd2});
    cnt = 0;
    while (busRdData[63] && cnt < 1000) begin cnt++; @(posedge clk); #1; end
    for (int i = 0; i < N; i++) if (ctxMatch(i, 2'd2, 16'd1, 16'd3)) mCV[i] = 0;
    check(busRdData == expReg(0, d), "R9 reg unchanged by busy write", busRdData, expReg(0, d));
    check(ctxValid == mCV, "R9 walk unchanged by busy write", 64'(ctxValid), 64'(mCV));

    // R10 drain hold
    fillAll();
    @(negedge clk); pendingReqs = 6'd3;
    d = {2'b10, 2'd1, 10'd0, 2'b11, 16'd0, 32'd0};
    busWrite(TLBA, d);
    repeat (N + 20) @(posedge clk); #1;
    check(busRdData[63] == 1'b1, "R10 busy held while pending", 64'(busRdData[63]), 1);
    @(negedge clk); pendingReqs = 6'd0;
    @(posedge clk); #1;
    check(busRdData[63] == 1'b0, "R10 busy clears after drain", 64'(busRdData[63]), 0);
    check(tlbValid == 0, "R10 R3 drained global clear", 64'(tlbValid), 0);
    mTV = '0;

    // Random mix for R3/R4/R5/R7/R8
    for (int it = 0; it < 40; it++) begin
      bit isTlb;
      logic [1:0] g;
      fillAll();
      isTlb = $urandom % 2;
      g = 2'($urandom % 4);
      if (isTlb) d = {2'b10, g, 12'd0, 16'(1 + $urandom % 3), 32'd0};
      else d = {1'b1, g, 29'd0, 16'(1 + $urandom % 3), 16'(1 + $urandom % 3)};
      doReq(isTlb, d, "R3/R4/R5/R7/R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule